// File: doc/BRIEF.md
# Watchdog Timer with Register Access and ALE Clock Output

This block guards a small 8-bit controller against a stalled program. Software reaches it through two byte-wide registers on a plain register bus: an address, write data, a write strobe and combinational read data. The control register turns the watchdog on, restarts its count and selects one of eight overflow periods. Each period is twice the length of the one below it. When the count runs out, the block raises a one-clock system reset request. It also records in a sticky flag that the watchdog caused the reset, so that software can find the cause after restart.

A clock prescaler sets the time base. It makes one tick every `TICK_DIV` clocks. The shortest period is 2^`BASE_BITS` ticks, and each step of the period select adds one bit to the terminal count. The configuration register also holds an inhibit bit. When this bit is clear, a free-running divide-by-`ALE_DIV` clock drives the address-latch-enable output. When it is set, the output stays low to reduce emissions.

Top module: `wdt_unit`

## Requirements
- R1: After `rst_n` is released, the control register reads 0x00, the configuration register reads 0x00 and `wdt_rst_req` is 0. The watchdog is disabled with period select 0.
- R2: The control register sits at address 0x9F. Bit 7 is the enable bit and bits 2:0 are the period select. Bit 4 is the restart strobe, which always reads 0. Bits 6, 5 and 3 read 0.
- R3: The configuration register sits at address 0xBF. Bit 7 is the watchdog-reset flag and bit 0 is the ALE inhibit bit. All its other bits read 0. A read at any other address returns 0x00, and a write to any other address changes no register.
- R4: After a control write that sets the enable bit with period select P, `wdt_rst_req` first goes high in the cycle that follows the TICK_DIV·2^(BASE_BITS+P)-th clock edge counted from the write edge.
- R5: A control write with bit 4 set restarts the count from zero. The next overflow then falls a full period after that write.
- R6: While the enable bit is 0, the count holds at zero and no reset request is made. Enabling again gives a full period.
- R7: A control write that changes the period select while the watchdog is enabled restarts the count with the new period. A rewrite of the same value with bit 4 clear does not disturb the running count.
- R8: On overflow, `wdt_rst_req` is high for exactly one cycle. The watchdog-reset flag is set, and the control register and the ALE inhibit bit return to 0.
- R9: The watchdog-reset flag survives a watchdog reset. Only `rst_n` or a configuration write clears it, and a configuration write loads bit 7 as written.
- R10: With the inhibit bit at 0, `ale_out` repeats with a period of ALE_DIV clocks and is high for ALE_DIV/2 clocks of each period. With the inhibit bit at 1, `ale_out` stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, sampled at the rising clock edge |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wdt_rst_req | output | 1 | One-clock system reset request on overflow |
| ale_out | output | 1 | Divided clock to the ALE pin, or low when inhibited |

## Verification
Register reads return data in the same cycle as the address. A write takes effect at the clock edge that samples the strobe. For a write at edge W, the reset request goes high right after edge W + TICK_DIV·2^(BASE_BITS+P). The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the write, so the count at which the request first appears must equal the expected period exactly. A mid-count rewrite must leave the remaining count intact, and the bench checks that it arrives at the period minus the falling edges already spent. The ALE output is sampled over two full divider periods at the falling edge.

// File: rtl/wdt_unit.sv
module wdt_unit #(
  parameter int TICK_DIV  = 4,
  parameter int BASE_BITS = 4,
  parameter int ALE_DIV   = 6,
  parameter logic [7:0] CTRL_ADDR = 8'h9F,
  parameter logic [7:0] CFG_ADDR  = 8'hBF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  output logic [7:0] reg_rdata,
  output logic       wdt_rst_req,
  output logic       ale_out
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = BASE_BITS + 8;
  localparam int DIV_W = $clog2(ALE_DIV);
  localparam int HALF  = ALE_DIV / 2;

  logic             wdt_en, alei, wdr;
  logic [2:0]       ps;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, term;
  logic [DIV_W-1:0] div;
  logic             ctrl_wr, cfg_wr, tick, restart, ovf;
  logic             unused_bits;

  assign unused_bits = ^{reg_wdata[6:5], reg_wdata[3]};

  assign ctrl_wr = reg_we && (reg_addr == CTRL_ADDR);
  assign cfg_wr  = reg_we && (reg_addr == CFG_ADDR);
  assign tick    = (pre == PRE_W'(TICK_DIV - 1));
  assign term    = CNT_W'((CNT_W'(1) << (BASE_BITS + int'(ps))) - CNT_W'(1));
  assign ovf     = wdt_en && tick && (cnt == term);
  assign restart = ctrl_wr && (reg_wdata[4] || (wdt_en && reg_wdata[2:0] != ps));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (ovf || restart || !wdt_en) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_en      <= 1'b0;
      ps          <= '0;
      alei        <= 1'b0;
      wdr         <= 1'b0;
      wdt_rst_req <= 1'b0;
    end else begin
      wdt_rst_req <= ovf;
      if (ovf) begin
        wdt_en <= 1'b0;
        ps     <= '0;
        alei   <= 1'b0;
        wdr    <= 1'b1;
      end else begin
        if (ctrl_wr) begin
          wdt_en <= reg_wdata[7];
          ps     <= reg_wdata[2:0];
        end
        if (cfg_wr) begin
          alei <= reg_wdata[0];
          wdr  <= reg_wdata[7];
        end
      end
    end
  end

  always_comb begin
    if (reg_addr == CTRL_ADDR)     reg_rdata = {wdt_en, 4'b0000, ps};
    else if (reg_addr == CFG_ADDR) reg_rdata = {wdr, 6'b000000, alei};
    else                           reg_rdata = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           div <= '0;
    else if (div == DIV_W'(ALE_DIV - 1))  div <= '0;
    else                                  div <= div + 1'b1;
  end

  assign ale_out = (div < DIV_W'(HALF)) && !alei;

  // R4
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre) < TICK_DIV);

  // R6
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_rst_req);

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);

  // R8
  req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> (wdr && !wdt_en && !alei && ps == 3'd0));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdr) |-> $past(cfg_wr && !reg_wdata[7]));

  // R10
  ale_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alei |-> !ale_out);
endmodule

// File: tb/test_wdt_unit.sv
module test_wdt_unit;
  localparam int TICK_DIV = 4;
  localparam int BASE_BITS = 4;
  localparam int ALE_DIV = 6;
  localparam logic [7:0] CTRL = 8'h9F;
  localparam logic [7:0] CFG  = 8'hBF;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic wdt_rst_req, ale_out;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  wdt_unit #(.TICK_DIV(TICK_DIV), .BASE_BITS(BASE_BITS), .ALE_DIV(ALE_DIV),
             .CTRL_ADDR(CTRL), .CFG_ADDR(CFG)) i_wdt_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .wdt_rst_req(wdt_rst_req),
    .ale_out(ale_out));

  function automatic int period(int p);
    return TICK_DIV << (BASE_BITS + p);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic quiet(int m, string tag);
    bit seen = 0;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      if (wdt_rst_req) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic expect_req(int n, string tag);
    int k = 0;
    bit seen = 0;
    while (!seen && k < n + 8) begin
      @(negedge clk); k++;
      if (wdt_rst_req) seen = 1;
    end
    chk(seen && k == n, tag, k, n);
    @(negedge clk);
    chk(!wdt_rst_req, "R8 request lasts one cycle", wdt_rst_req, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout (R1..) actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [11:0] smp;
    void'($urandom(32'd1234));
    do_reset();

    rd(CTRL, v); chk(v == 8'h00, "R1 control after reset", v, 0);
    rd(CFG, v);  chk(v == 8'h00, "R1 config after reset", v, 0);
    chk(!wdt_rst_req, "R1 no request after reset", wdt_rst_req, 0);

    wr(CTRL, 8'h7B);
    rd(CTRL, v); chk(v == 8'h03, "R2 unused and strobe bits read 0", v, 8'h03);
    wr(CTRL, 8'h00);
    wr(CFG, 8'h7F);
    rd(CFG, v); chk(v == 8'h01, "R3 config unused bits read 0", v, 1);
    wr(CFG, 8'h00);
    wr(8'h80, 8'hFF);
    rd(CTRL, v); chk(v == 8'h00, "R3 stray write leaves control", v, 0);
    rd(CFG, v);  chk(v == 8'h00, "R3 stray write leaves config", v, 0);
    rd(8'h80, v); chk(v == 8'h00, "R3 other address reads 0", v, 0);

    wr(CTRL, 8'h80); expect_req(period(0), "R4 period select 0");
    rd(CFG, v);  chk(v == 8'h80, "R8 flag set after overflow", v, 8'h80);
    rd(CTRL, v); chk(v == 8'h00, "R8 control cleared by overflow", v, 0);

    wr(CFG, 8'h81);
    wr(CTRL, 8'h87); expect_req(period(7), "R4 period select 7");
    rd(CFG, v); chk(v == 8'h80, "R8 inhibit cleared, R9 flag kept", v, 8'h80);
    wr(CFG, 8'h01);
    rd(CFG, v); chk(v == 8'h01, "R9 write 0 clears flag", v, 1);
    wr(CFG, 8'h80);
    rd(CFG, v); chk(v == 8'h80, "R9 write loads flag", v, 8'h80);
    do_reset();
    rd(CFG, v); chk(v == 8'h00, "R9 power-on reset clears flag", v, 0);

    wr(CTRL, 8'h80); quiet(30, "R6 counting");
    wr(CTRL, 8'h00); quiet(3 * period(0), "R6 disabled gives no request");
    wr(CTRL, 8'h80); expect_req(period(0), "R6 full period after re-enable");

    for (int t = 0; t < 24; t++) begin
      int p = $urandom % 4;
      int n = period(p);
      int m = 1 + $urandom % (n - 3);
      int mode = $urandom % 3;
      wr(CTRL, 8'h80 | 8'(p));
      quiet(m, "R4 early request");
      if (mode == 0) begin
        wr(CTRL, 8'h90 | 8'(p)); expect_req(n, "R5 restart strobe");
      end else if (mode == 1) begin
        int p2 = (p + 1 + $urandom % 3) % 4;
        wr(CTRL, 8'h80 | 8'(p2)); expect_req(period(p2), "R7 period change restarts");
      end else begin
        wr(CTRL, 8'h80 | 8'(p)); expect_req(n - m - 2, "R7 same value keeps count");
      end
    end

    wr(CFG, 8'h00);
    for (int i = 0; i < 12; i++) begin @(negedge clk); smp[i] = ale_out; end
    chk($countones(smp) == ALE_DIV, "R10 ALE duty", $countones(smp), ALE_DIV);
    chk(smp[5:0] == smp[11:6], "R10 ALE period", smp[11:6], smp[5:0]);
    wr(CFG, 8'h01);
    for (int i = 0; i < 12; i++) begin @(negedge clk); smp[i] = ale_out; end
    chk(smp == 12'h000, "R10 ALE inhibited", smp, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule